// File: doc/BRIEF.md
# Single-precision chained multiply-add slice

The slice is a pipelined IEEE-754 single-precision arithmetic element with two modes. In multiplication mode it multiplies two 32-bit operands and returns the rounded product. In multiply-add mode it multiplies the operands and adds the product to a 32-bit addend. The addend is either the chain input or, when accumulation is selected, the slice's own previous result. A subtract control negates the product before the addition. The multiplier and the adder each report their own set of four exception flags.

Slices are meant to be cascaded. A first slice in multiplication mode forms one partial product and drives it on its chain output. A second slice in multiply-add mode takes that value on its chain input and adds or subtracts its own product. Two such pairs give the imaginary part a×d + b×c and the real part a×c − b×d of a complex product. The chain input is sampled together with the operands, so the second slice is issued four cycles after the first.

Top module: `fp_chain_slice`

## Requirements
- R1: An operation presented with valid_i high in cycle n appears with valid_o high in cycle n+4 (the fourth rising edge after it is presented). Operations may be issued in consecutive cycles.
- R2: With madd_i low, result_o is the product op_a_i×op_b_i rounded to nearest even, and add_flags_o is 0. sub_i and acc_i have no effect in this mode.
- R3: With madd_i high and acc_i low, result_o is chain_i + op_a_i×op_b_i. The product is rounded first and the sum is rounded to nearest even. mul_flags_o reports the multiply and add_flags_o reports the addition.
- R4: With madd_i high, sub_i high flips the sign of the product before the addition, so the result is chain_i − op_a_i×op_b_i. An exact zero difference is +0.
- R5: With madd_i high and acc_i high, the addend is the current value of result_o and chain_i is ignored. The previous operation must have been issued at least two cycles earlier.
- R6: A NaN operand, infinity×0, or the sum of opposite-signed infinities gives 0x7FC00000 and sets the invalid flag, which is bit 3, in the flag set of the stage concerned.
- R7: A result whose exponent exceeds the single-precision range gives a correctly signed infinity and sets both overflow (bit 2) and inexact (bit 0).
- R8: A zero-exponent input is treated as a signed zero and raises no flag. A result below the normal range is flushed to a signed zero and sets underflow (bit 1) and inexact (bit 0).
- R9: A result that had to be rounded sets inexact (bit 0), and ties round to the even mantissa.
- R10: result_o, chain_o and both flag sets change only in cycles with valid_o high and hold their value otherwise. chain_o always equals result_o.
- R11: After reset, valid_o, result_o, chain_o and both flag sets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are present this cycle |
| madd_i | input | 1 | 1: multiply-add mode, 0: multiplication mode |
| sub_i | input | 1 | Negate the product before the addition |
| acc_i | input | 1 | Use the previous result as addend instead of chain_i |
| op_a_i | input | 32 | First multiplier operand |
| op_b_i | input | 32 | Second multiplier operand |
| chain_i | input | 32 | Addend from the preceding slice |
| valid_o | output | 1 | Result and flags are new this cycle |
| result_o | output | 32 | Registered result |
| chain_o | output | 32 | Result driven toward the next slice |
| mul_flags_o | output | 4 | Multiplier flags {invalid, overflow, underflow, inexact} |
| add_flags_o | output | 4 | Adder flags {invalid, overflow, underflow, inexact} |

## Verification
The hardest case to reach from the ports is the adder's own exception behaviour. For the adder to overflow, round a tie or see opposite infinities, the multiplier must first deliver a specific clean product. So the operands are picked to give exact products (×1.0, powers of two), which puts the chosen value on the adder input with the multiplier flags clear. Accumulation depends on the output register that is fed back. The stimulus therefore lets a known result settle, then issues accumulate operations with a deliberately wrong chain_i, so that any use of the chain value shows in the result.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned FpW   = 32;
  localparam int unsigned ExpW  = 8;
  localparam int unsigned ManW  = 23;
  localparam int unsigned ExtW  = ManW + 4;   // hidden + mantissa + guard/round/sticky
  localparam logic [FpW-1:0] QNAN = 32'h7FC0_0000;
  localparam logic [ExpW-1:0] EMAX = '1;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fp_flags_t;

  typedef struct packed {
    logic [FpW-1:0] val;
    fp_flags_t      flg;
  } fp_res_t;

  typedef struct packed {
    logic madd;
    logic sub;
    logic acc;
  } fpc_ctrl_t;

  function automatic fp_res_t fp_round(input logic sgn, input logic signed [9:0] e,
                                       input logic [ManW-1:0] m, input logic g, input logic st);
    fp_res_t r;
    logic [ManW:0] mr;
    logic signed [9:0] e2;
    logic inc;
    inc = g & (st | m[0]);
    mr  = {1'b0, m} + {{ManW{1'b0}}, inc};
    e2  = e + $signed({9'b0, mr[ManW]});
    r.flg = '0;
    r.flg.inexact = g | st;
    if (e2 >= 10'sd255) begin
      r.val = {sgn, EMAX, {ManW{1'b0}}};
      r.flg.overflow = 1'b1;
      r.flg.inexact  = 1'b1;
    end else if (e2 <= 10'sd0) begin
      r.val = {sgn, {(FpW-1){1'b0}}};
      r.flg.underflow = 1'b1;
      r.flg.inexact   = 1'b1;
    end else begin
      r.val = {sgn, e2[ExpW-1:0], mr[ManW-1:0]};
    end
    return r;
  endfunction

  function automatic fp_res_t fp_mul(input logic [FpW-1:0] a, input logic [FpW-1:0] b);
    fp_res_t r;
    logic sgn, a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
    logic [2*ManW+1:0] sig;
    logic signed [9:0] e;
    sgn    = a[31] ^ b[31];
    a_nan  = (a[30:23] == EMAX) && (a[22:0] != '0);
    b_nan  = (b[30:23] == EMAX) && (b[22:0] != '0);
    a_inf  = (a[30:23] == EMAX) && (a[22:0] == '0);
    b_inf  = (b[30:23] == EMAX) && (b[22:0] == '0);
    a_zero = (a[30:23] == '0);
    b_zero = (b[30:23] == '0);
    sig    = {1'b1, a[22:0]} * {1'b1, b[22:0]};
    e      = $signed({2'b00, a[30:23]}) + $signed({2'b00, b[30:23]}) - 10'sd127;
    r.flg  = '0;
    if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero)) begin
      r.val = QNAN;
      r.flg.invalid = 1'b1;
    end else if (a_inf || b_inf) begin
      r.val = {sgn, EMAX, {ManW{1'b0}}};
    end else if (a_zero || b_zero) begin
      r.val = {sgn, {(FpW-1){1'b0}}};
    end else if (sig[47]) begin
      r = fp_round(sgn, e + 10'sd1, sig[46:24], sig[23], |sig[22:0]);
    end else begin
      r = fp_round(sgn, e, sig[45:23], sig[22], |sig[21:0]);
    end
    return r;
  endfunction

  function automatic fp_res_t fp_add(input logic [FpW-1:0] x, input logic [FpW-1:0] y);
    fp_res_t r;
    logic [FpW-1:0] big, sml;
    logic x_nan, y_nan, x_inf, y_inf, x_zero, y_zero;
    logic [ExpW-1:0] d;
    logic [ExtW-1:0] ext_b, ext_s, sh_s, nrm;
    logic [ExtW:0] sum;
    logic [4:0] pos, shl;
    logic signed [9:0] e;
    x_nan  = (x[30:23] == EMAX) && (x[22:0] != '0);
    y_nan  = (y[30:23] == EMAX) && (y[22:0] != '0);
    x_inf  = (x[30:23] == EMAX) && (x[22:0] == '0);
    y_inf  = (y[30:23] == EMAX) && (y[22:0] == '0);
    x_zero = (x[30:23] == '0);
    y_zero = (y[30:23] == '0);
    if (x[30:0] < y[30:0]) begin big = y; sml = x; end
    else begin big = x; sml = y; end
    d     = big[30:23] - sml[30:23];
    ext_b = {1'b1, big[22:0], 3'b000};
    ext_s = {1'b1, sml[22:0], 3'b000};
    if (d >= ExpW'(ExtW)) begin
      sh_s = {{(ExtW-1){1'b0}}, 1'b1};
    end else begin
      sh_s = ext_s >> d;
      sh_s[0] = sh_s[0] | (|(ext_s & ((ExtW'(1) << d) - ExtW'(1))));
    end
    if (big[31] ^ sml[31]) sum = {1'b0, ext_b} - {1'b0, sh_s};
    else                   sum = {1'b0, ext_b} + {1'b0, sh_s};
    pos = '0;
    for (int i = 0; i < ExtW; i++) if (sum[i]) pos = 5'(i);
    shl = 5'(ExtW - 1) - pos;
    e   = $signed({2'b00, big[30:23]});
    r.flg = '0;
    if (x_nan || y_nan || (x_inf && y_inf && (x[31] != y[31]))) begin
      r.val = QNAN;
      r.flg.invalid = 1'b1;
    end else if (x_inf) begin
      r.val = x;
    end else if (y_inf) begin
      r.val = y;
    end else if (x_zero && y_zero) begin
      r.val = {x[31] & y[31], {(FpW-1){1'b0}}};
    end else if (x_zero) begin
      r.val = y;
    end else if (y_zero) begin
      r.val = x;
    end else if (sum == '0) begin
      r.val = '0;
    end else if (sum[ExtW]) begin
      nrm = sum[ExtW:1] | {{(ExtW-1){1'b0}}, sum[0]};
      r = fp_round(big[31], e + 10'sd1, nrm[25:3], nrm[2], |nrm[1:0]);
    end else begin
      nrm = sum[ExtW-1:0] << shl;
      r = fp_round(big[31], e - $signed({5'b0, shl}), nrm[25:3], nrm[2], |nrm[1:0]);
    end
    return r;
  endfunction
endpackage

// File: rtl/fpc_mul_stage.sv
module fpc_mul_stage
  import fpc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  fpc_ctrl_t      ctrl_i,
  input  logic [FpW-1:0] a_i,
  input  logic [FpW-1:0] b_i,
  input  logic [FpW-1:0] chain_i,
  output logic           vld_o,
  output fpc_ctrl_t      ctrl_o,
  output logic [FpW-1:0] prod_o,
  output fp_flags_t      flg_o,
  output logic [FpW-1:0] chain_o
);
  fp_res_t prod_d;
  assign prod_d = fp_mul(a_i, b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      ctrl_o  <= '0;
      prod_o  <= '0;
      flg_o   <= '0;
      chain_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        ctrl_o  <= ctrl_i;
        prod_o  <= prod_d.val;
        flg_o   <= prod_d.flg;
        chain_o <= chain_i;
      end
    end
  end
endmodule

// File: rtl/fpc_add_stage.sv
module fpc_add_stage
  import fpc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  fpc_ctrl_t      ctrl_i,
  input  logic [FpW-1:0] prod_i,
  input  fp_flags_t      mflg_i,
  input  logic [FpW-1:0] chain_i,
  input  logic [FpW-1:0] acc_i,
  output logic           vld_o,
  output logic [FpW-1:0] res_o,
  output fp_flags_t      mflg_o,
  output fp_flags_t      aflg_o
);
  logic [FpW-1:0] addend, term;
  fp_res_t sum_d;

  assign addend = ctrl_i.acc ? acc_i : chain_i;
  assign term   = {prod_i[FpW-1] ^ ctrl_i.sub, prod_i[FpW-2:0]};
  assign sum_d  = fp_add(addend, term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      res_o  <= '0;
      mflg_o <= '0;
      aflg_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        mflg_o <= mflg_i;
        if (ctrl_i.madd) begin
          res_o  <= sum_d.val;
          aflg_o <= sum_d.flg;
        end else begin
          res_o  <= prod_i;
          aflg_o <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fp_chain_slice.sv
module fp_chain_slice
  import fpc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        madd_i,
  input  logic        sub_i,
  input  logic        acc_i,
  input  logic [31:0] op_a_i,
  input  logic [31:0] op_b_i,
  input  logic [31:0] chain_i,
  output logic        valid_o,
  output logic [31:0] result_o,
  output logic [31:0] chain_o,
  output logic [3:0]  mul_flags_o,
  output logic [3:0]  add_flags_o
);
  logic           s1_vld, s2_vld, s3_vld;
  fpc_ctrl_t      s1_ctrl, s2_ctrl;
  logic [FpW-1:0] s1_a, s1_b, s1_c, s2_prod, s2_c, s3_res, res_q;
  fp_flags_t      s2_mflg, s3_mflg, s3_aflg, mflg_q, aflg_q;

  // input register bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_ctrl <= '0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_c    <= '0;
    end else begin
      s1_vld <= valid_i;
      if (valid_i) begin
        s1_ctrl <= '{madd: madd_i, sub: sub_i, acc: acc_i};
        s1_a    <= op_a_i;
        s1_b    <= op_b_i;
        s1_c    <= chain_i;
      end
    end
  end

  fpc_mul_stage u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s1_vld),
    .ctrl_i  (s1_ctrl),
    .a_i     (s1_a),
    .b_i     (s1_b),
    .chain_i (s1_c),
    .vld_o   (s2_vld),
    .ctrl_o  (s2_ctrl),
    .prod_o  (s2_prod),
    .flg_o   (s2_mflg),
    .chain_o (s2_c)
  );

  fpc_add_stage u_add (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s2_vld),
    .ctrl_i  (s2_ctrl),
    .prod_i  (s2_prod),
    .mflg_i  (s2_mflg),
    .chain_i (s2_c),
    .acc_i   (res_q),
    .vld_o   (s3_vld),
    .res_o   (s3_res),
    .mflg_o  (s3_mflg),
    .aflg_o  (s3_aflg)
  );

  // output register bank; res_q also feeds the accumulate loop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_q   <= '0;
      mflg_q  <= '0;
      aflg_q  <= '0;
    end else begin
      valid_o <= s3_vld;
      if (s3_vld) begin
        res_q  <= s3_res;
        mflg_q <= s3_mflg;
        aflg_q <= s3_aflg;
      end
    end
  end

  assign result_o    = res_q;
  assign chain_o     = res_q;
  assign mul_flags_o = mflg_q;
  assign add_flags_o = aflg_q;
endmodule

// File: rtl/fp_chain_slice_chk.sv
module fp_chain_slice_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        madd_i,
  input logic        valid_o,
  input logic [31:0] result_o,
  input logic [3:0]  mul_flags_o,
  input logic [3:0]  add_flags_o
);
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4) |-> (valid_o == $past(valid_i, 4))); // R1

  AST_MUL_MODE_ADD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4 && valid_o && !$past(madd_i, 4)) |-> (add_flags_o == 4'b0)); // R2

  AST_NAN_CANONICAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o[30:23] == 8'hFF && result_o[22:0] != '0) |-> (result_o == 32'h7FC0_0000)); // R6

  AST_NAN_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o == 32'h7FC0_0000) |-> (mul_flags_o[3] || add_flags_o[3])); // R6

  AST_MUL_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mul_flags_o[2]) |-> mul_flags_o[0]); // R7

  AST_ADD_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && add_flags_o[2]) |-> add_flags_o[0]); // R7

  AST_NO_DENORM_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(result_o[30:23] == 8'h00 && result_o[22:0] != '0)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> valid_o); // R10
endmodule

bind fp_chain_slice fp_chain_slice_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .madd_i      (madd_i),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .mul_flags_o (mul_flags_o),
  .add_flags_o (add_flags_o)
);

// File: tb/fp_chain_slice_bench.sv
module fp_chain_slice_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, madd_i = 1'b0, sub_i = 1'b0, acc_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0, chain_i = '0;
  logic valid_o;
  logic [31:0] result_o, chain_o;
  logic [3:0] mul_flags_o, add_flags_o;

  fp_chain_slice u_fp_chain_slice (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .madd_i(madd_i), .sub_i(sub_i),
    .acc_i(acc_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .chain_i(chain_i),
    .valid_o(valid_o), .result_o(result_o), .chain_o(chain_o),
    .mul_flags_o(mul_flags_o), .add_flags_o(add_flags_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  mf;
    logic [3:0]  af;
    int          cyc;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  logic [31:0] last_res = '0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, expv);
    end
  endtask

  // driver: flags {invalid, overflow, underflow, inexact}
  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                      input logic md, input logic sb, input logic ac,
                      input logic [31:0] res, input logic [3:0] mf, input logic [3:0] af,
                      input string tag);
    item_t it;
    @(negedge clk);
    valid_i = 1'b1; op_a_i = a; op_b_i = b; chain_i = c;
    madd_i = md; sub_i = sb; acc_i = ac;
    it.res = res; it.mf = mf; it.af = af; it.cyc = cyc; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    valid_i = 1'b0; madd_i = 1'b0; sub_i = 1'b0; acc_i = 1'b0;
    op_a_i = 32'hDEAD_BEEF; chain_i = 32'h1234_5678;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected valid_o", 32'h1, 32'h0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(cyc == it.cyc + 4, "R1", "latency", 32'(cyc - it.cyc), 32'd4);
        check(result_o == it.res, it.tag, "result", result_o, it.res);
        check(mul_flags_o == it.mf, it.tag, "mul flags", {28'b0, mul_flags_o}, {28'b0, it.mf});
        check(add_flags_o == it.af, it.tag, "add flags", {28'b0, add_flags_o}, {28'b0, it.af});
        check(chain_o == result_o, "R10", "chain_o", chain_o, result_o);
        last_res = it.res;
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(valid_o == 1'b0, "R11", "valid_o", {31'b0, valid_o}, 32'h0);
    check(result_o == 32'h0, "R11", "result_o", result_o, 32'h0);
    check(chain_o == 32'h0, "R11", "chain_o", chain_o, 32'h0);
    check({mul_flags_o, add_flags_o} == 8'h0, "R11", "flags",
          {24'b0, mul_flags_o, add_flags_o}, 32'h0);

    // R2 multiplication mode, sub/acc ignored
    send(32'h4000_0000, 32'h4040_0000, 32'h3F80_0000, 1'b0, 1'b1, 1'b1, 32'h40C0_0000, 4'h0, 4'h0, "R2");
    idle(6);
    // R1 back-to-back burst
    send(32'h4000_0000, 32'h4040_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h40C0_0000, 4'h0, 4'h0, "R1");
    send(32'h3F80_0000, 32'h3F80_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h3F80_0000, 4'h0, 4'h0, "R1");
    send(32'hC000_0000, 32'h4040_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'hC0C0_0000, 4'h0, 4'h0, "R1");
    idle(6);
    // R10 hold while idle
    check(result_o == last_res, "R10", "hold", result_o, last_res);
    // R3 multiply-add: 1.5*2 + 1 = 4
    send(32'h3FC0_0000, 32'h4000_0000, 32'h3F80_0000, 1'b1, 1'b0, 1'b0, 32'h4080_0000, 4'h0, 4'h0, "R3");
    idle(6);
    // R4 subtract: 0 - 2*3 is exercised as 6 - 6 = +0
    send(32'h4000_0000, 32'h4040_0000, 32'h40C0_0000, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 4'h0, 4'h0, "R4");
    idle(6);
    // R4 subtract: 10 - 2*3 = 4
    send(32'h4000_0000, 32'h4040_0000, 32'h4120_0000, 1'b1, 1'b1, 1'b0, 32'h4080_0000, 4'h0, 4'h0, "R4");
    idle(6);
    // R5 accumulate: 4 + 1*1 = 5, chain_i ignored
    send(32'h3F80_0000, 32'h3F80_0000, 32'h42C8_0000, 1'b1, 1'b0, 1'b1, 32'h40A0_0000, 4'h0, 4'h0, "R5");
    idle(6);
    send(32'h3F80_0000, 32'h3F80_0000, 32'hC2C8_0000, 1'b1, 1'b0, 1'b1, 32'h40C0_0000, 4'h0, 4'h0, "R5");
    idle(6);
    check(result_o == 32'h40C0_0000, "R10", "hold after accumulate", result_o, 32'h40C0_0000);
    // R9 rounding
    send(32'h3F80_0001, 32'h3F80_0001, 32'h0, 1'b0, 1'b0, 1'b0, 32'h3F80_0002, 4'h1, 4'h0, "R9");
    send(32'h3F80_0001, 32'h3FC0_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h3FC0_0002, 4'h1, 4'h0, "R9");
    send(32'h3F80_0000, 32'h3380_0000, 32'h3F80_0000, 1'b1, 1'b0, 1'b0, 32'h3F80_0000, 4'h0, 4'h1, "R9");
    // R7 overflow
    send(32'h7F00_0000, 32'h4000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h7F80_0000, 4'h5, 4'h0, "R7");
    send(32'hFF00_0000, 32'h4000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'hFF80_0000, 4'h5, 4'h0, "R7");
    send(32'h7F7F_FFFF, 32'h3F80_0000, 32'h7F7F_FFFF, 1'b1, 1'b0, 1'b0, 32'h7F80_0000, 4'h0, 4'h5, "R7");
    // R6 invalid
    send(32'h7F80_0000, 32'h0000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h7FC0_0000, 4'h8, 4'h0, "R6");
    send(32'h7FA0_0000, 32'h3F80_0000, 32'h3F80_0000, 1'b1, 1'b0, 1'b0, 32'h7FC0_0000, 4'h8, 4'h8, "R6");
    send(32'h7F80_0000, 32'h3F80_0000, 32'h7F80_0000, 1'b1, 1'b1, 1'b0, 32'h7FC0_0000, 4'h0, 4'h8, "R6");
    // R8 flush to zero
    send(32'h0080_0000, 32'h3F00_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 4'h3, 4'h0, "R8");
    send(32'h8080_0000, 32'h3F00_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 4'h3, 4'h0, "R8");
    send(32'h0040_0000, 32'h4000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 4'h0, 4'h0, "R8");
    idle(8);
    check(exp_q.size() == 0, "R1", "results outstanding", 32'(exp_q.size()), 32'h0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule